// File: doc/BRIEF.md
# Write-Protection Sequence Detector

This block sits beside the host write path of a nonvolatile memory and decides, for each host write, whether the write may reach the array. It watches every write cycle (full 16-bit address and data byte) and recognises short command sequences written to two fixed low addresses. While global protection is on, an array write must follow a three-byte unlock sequence and must arrive within a gap window. A five-byte sequence switches global protection off. A different five-byte sequence opens an 8-bit block-lock register for one write.

Each bit of the block-lock register vetoes writes to one 1K-byte block, whatever the global protection state. Every command byte must carry a configured 3-bit region value in address bits 15:13. It must also carry the plane bit (address bit 12) of the plane it addresses. The nonvolatile settings are modelled as flops with a reset default.

Top module: `wp_guard`

## Requirements
- R1: After reset, global protection is on (`prot_on` = 1) and the block-lock map is all zeros.
- R2: While global protection is on, a write that does not follow a complete unlock sequence gives `wr_allow` = 0.
- R3: The unlock sequence is data 0xAA at low address 0x555, then 0x55 at 0xAAA, then 0xA0 at 0x555. After it, writes whose bit 12 equals the sequence's plane bit are allowed, and writes to the other plane are refused.
- R4: Idle cycles are cycles with no write. A write that follows WINDOW or more idle cycles finds the detector idle, so a half-entered sequence or an open burst is dropped. Fewer than WINDOW idle cycles keep the sequence or burst alive.
- R5: The sequence 0xAA@0x555, 0x55@0xAAA, 0xA0@0x555, 0xAA@0x555, 0x80@0xAAA switches global protection off. Writes are then allowed without unlocking.
- R6: The sequence 0xAA@0x555, 0x55@0xAAA, 0xA0@0x555, 0xAA@0x555, 0x40@0xAAA arms a lock load. The next write stores its data byte in the lock map and turns global protection back on. That write is not an array write.
- R7: `wr_allow` is 0 for any write whose block index (address bits 12:10) has its lock bit set, even with protection off or unlocked. The lock map changes only through R6.
- R8: Every byte consumed as a sequence step gives `wr_allow` = 0, including 0xAA@0x555 while protection is off. A wrong byte in the middle of a sequence returns the detector to idle and is refused.
- R9: A command byte counts only when address bits 15:13 equal `cmd_region` and bit 12 equals the plane bit of the sequence's first byte.
- R10: `wr_allow` is a combinational decision, valid in the same cycle as `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A host write is present this cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data byte |
| cmd_region | input | 3 | Configured value that command address bits 15:13 must match |
| wr_allow | output | 1 | The current write may program the array |
| prot_on | output | 1 | Global protection state |
| lock_map | output | 8 | Block-lock bits, one per 1K block |

## Verification
The assertions take for granted that `wr_valid` pulses only for real host writes. They also assume `cmd_region` holds steady across a sequence. Under those assumptions, the lock map can move only on a write and only into a protected state, and protection can drop only on a 0x80@0xAAA write. The bench keeps `cmd_region` fixed. It separates writes by at least one idle cycle, and places gaps deliberately just inside and just outside the window. Its random writes never carry 0xAA, so no sequence can start by accident.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    localparam logic [11:0] LO_A   = 12'h555;
    localparam logic [11:0] LO_B   = 12'hAAA;
    localparam logic [7:0]  D_OPEN = 8'hAA;
    localparam logic [7:0]  D_TWO  = 8'h55;
    localparam logic [7:0]  D_UNLK = 8'hA0;
    localparam logic [7:0]  D_OFF  = 8'h80;
    localparam logic [7:0]  D_LOCK = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_B1,
        ST_B2,
        ST_OPEN,
        ST_B4,
        ST_LOAD,
        ST_BURST
    } step_e;

    typedef struct packed {
        logic mem_ok;
        logic clr_prot;
        logic ld_lock;
    } act_t;

    function automatic logic cmd_hit(
        input logic [15:0] a,
        input logic [7:0]  d,
        input logic [2:0]  region,
        input logic        plane,
        input logic [11:0] lo,
        input logic [7:0]  val
    );
        return (a[15:13] == region) && (a[12] == plane) &&
               (a[11:0] == lo) && (d == val);
    endfunction

endpackage

// File: rtl/wpg_gap_timer.sv
module wpg_gap_timer #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_valid,
    output logic expired
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LIM = CW'(WINDOW);

    logic [CW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= '0;
        else if (wr_valid)
            gap_q <= '0;
        else if (gap_q != LIM)
            gap_q <= gap_q + 1'b1;
    end

    assign expired = (gap_q >= LIM);
endmodule

// File: rtl/wpg_seq_fsm.sv
module wpg_seq_fsm
    import wpg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        expired,
    input  logic        wr_valid,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  cmd_region,
    input  logic        prot_on,
    output act_t        act
);
    step_e step_q, cur, nxt;
    logic  plane_q, nplane, same_plane;

    assign cur        = expired ? ST_IDLE : step_q;
    assign same_plane = (wr_addr[12] == plane_q);

    always_comb begin
        nxt    = cur;
        nplane = plane_q;
        act    = '0;
        if (wr_valid) begin
            case (cur)
                ST_IDLE: begin
                    if (cmd_hit(wr_addr, wr_data, cmd_region, wr_addr[12], LO_A, D_OPEN)) begin
                        nxt    = ST_B1;
                        nplane = wr_addr[12];
                    end else begin
                        act.mem_ok = ~prot_on;
                    end
                end
                ST_B1: nxt = cmd_hit(wr_addr, wr_data, cmd_region, plane_q, LO_B, D_TWO)
                             ? ST_B2 : ST_IDLE;
                ST_B2: nxt = cmd_hit(wr_addr, wr_data, cmd_region, plane_q, LO_A, D_UNLK)
                             ? ST_OPEN : ST_IDLE;
                ST_OPEN: begin
                    if (cmd_hit(wr_addr, wr_data, cmd_region, plane_q, LO_A, D_OPEN)) begin
                        nxt = ST_B4;
                    end else if (same_plane || !prot_on) begin
                        act.mem_ok = 1'b1;
                        nxt        = ST_BURST;
                    end
                end
                ST_B4: begin
                    if (cmd_hit(wr_addr, wr_data, cmd_region, plane_q, LO_B, D_OFF)) begin
                        act.clr_prot = 1'b1;
                        nxt          = ST_IDLE;
                    end else if (cmd_hit(wr_addr, wr_data, cmd_region, plane_q, LO_B, D_LOCK)) begin
                        nxt = ST_LOAD;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_LOAD: begin
                    act.ld_lock = 1'b1;
                    nxt         = ST_IDLE;
                end
                ST_BURST: act.mem_ok = same_plane || !prot_on;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_IDLE;
            plane_q <= 1'b0;
        end else begin
            step_q  <= nxt;
            plane_q <= nplane;
        end
    end
endmodule

// File: rtl/wpg_lock_bank.sv
module wpg_lock_bank #(
    parameter int          BLOCKS    = 8,
    parameter logic [BLOCKS-1:0] LOCK_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lock,
    input  logic              clr_prot,
    input  logic [BLOCKS-1:0] ld_val,
    output logic              prot_q,
    output logic [BLOCKS-1:0] lock_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= 1'b1;
            lock_q <= LOCK_INIT;
        end else if (ld_lock) begin
            prot_q <= 1'b1;
            lock_q <= ld_val;
        end else if (clr_prot) begin
            prot_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wpg_pkg::*;
#(
    parameter int WINDOW = 16,
    parameter int BLOCKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        cmd_region,
    output logic              wr_allow,
    output logic              prot_on,
    output logic [BLOCKS-1:0] lock_map
);
    localparam int BLK_W   = $clog2(BLOCKS);
    localparam int BLK_LSB = 13 - BLK_W;

    logic             expired;
    act_t             act;
    logic [BLK_W-1:0] blk;

    wpg_gap_timer #(.WINDOW(WINDOW)) u_gap (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .expired(expired)
    );

    wpg_seq_fsm u_seq (
        .clk(clk), .rst(rst), .expired(expired), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .cmd_region(cmd_region),
        .prot_on(prot_on), .act(act)
    );

    wpg_lock_bank #(.BLOCKS(BLOCKS)) u_lock (
        .clk(clk), .rst(rst), .ld_lock(act.ld_lock), .clr_prot(act.clr_prot),
        .ld_val(wr_data[BLOCKS-1:0]), .prot_q(prot_on), .lock_q(lock_map)
    );

    assign blk      = wr_addr[BLK_LSB +: BLK_W];
    assign wr_allow = wr_valid & act.mem_ok & ~lock_map[blk];
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        wr_allow,
    input logic        prot_on,
    input logic [7:0]  lock_map
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prot_on && lock_map == 8'h00));

    a_r7_lock_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(lock_map));

    a_r6_reprotect: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_map) |-> prot_on);

    a_r6_rise_on_write: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_on) |-> $past(wr_valid));

    a_r5_drop_cmd: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_on) |-> ($past(wr_valid) && $past(wr_data) == 8'h80 &&
                            $past(wr_addr[11:0]) == 12'hAAA));

    a_r7_lock_veto: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && lock_map[wr_addr[12:10]]) |-> !wr_allow);
endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_allow(wr_allow), .prot_on(prot_on),
    .lock_map(lock_map)
);

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
    localparam int WIN = 16;
    localparam logic [2:0] REG = 3'b101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  cmd_region = REG;
    logic        wr_allow, prot_on;
    logic [7:0]  lock_map;
    int checks = 0, errors = 0;
    logic got;

    always #2 clk = ~clk;

    wp_guard #(.WINDOW(WIN), .BLOCKS(8)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_region(cmd_region), .wr_allow(wr_allow),
        .prot_on(prot_on), .lock_map(lock_map)
    );

    function automatic logic [15:0] ca(input logic pl, input logic [11:0] lo);
        return {REG, pl, lo};
    endfunction

    function automatic logic [15:0] ma(input logic [2:0] blk, input logic [9:0] off);
        return {3'b000, blk, off};
    endfunction

    function automatic logic exp_open(input logic [7:0] lk, input logic [15:0] a);
        return !lk[a[12:10]];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, output logic g);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1 g = wr_allow;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic pl, input logic [11:0] lo, input logic [7:0] d);
        logic g;
        wr(ca(pl, lo), d, g);
        chk("R8 command byte refused", {7'd0, g}, 8'd0);
    endtask

    task automatic unlock(input logic pl);
        cmd(pl, 12'h555, 8'hAA); cmd(pl, 12'hAAA, 8'h55); cmd(pl, 12'h555, 8'hA0);
    endtask

    task automatic deact(input logic pl);
        unlock(pl); cmd(pl, 12'h555, 8'hAA); cmd(pl, 12'hAAA, 8'h80);
    endtask

    task automatic setlock(input logic pl, input logic [7:0] v);
        logic g;
        unlock(pl); cmd(pl, 12'h555, 8'hAA); cmd(pl, 12'hAAA, 8'h40);
        wr(ma(3'd2, 10'h11), v, g);
        chk("R6 load write not an array write", {7'd0, g}, 8'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rl;
        void'($urandom(32'd1234));
        idle(3);
        rst = 1'b0;
        #1;
        chk("R1 prot_on after reset", {7'd0, prot_on}, 8'd1);
        chk("R1 lock map after reset", lock_map, 8'h00);

        // R2: plain write while protected
        wr(ma(3'd1, 10'h5), 8'h3C, got);
        chk("R2 unprotected-less write", {7'd0, got}, 8'd0);

        // R3 / R10: unlock plane 0, same-cycle allow
        unlock(1'b0);
        wr(ma(3'd0, 10'h20), 8'h11, got); chk("R3 R10 burst write plane0", {7'd0, got}, 8'd1);
        wr(ma(3'd3, 10'h21), 8'h12, got); chk("R3 second burst write", {7'd0, got}, 8'd1);
        wr(ma(3'd4, 10'h22), 8'h13, got); chk("R3 other plane refused", {7'd0, got}, 8'd0);
        idle(WIN + 2);
        wr(ma(3'd0, 10'h23), 8'h14, got); chk("R4 burst closed after gap", {7'd0, got}, 8'd0);

        // R4 boundary: WIN-2 idle cycles keep, WIN+1 drop
        unlock(1'b1);
        idle(WIN - 3);
        wr(ma(3'd5, 10'h1), 8'h21, got); chk("R4 gap inside window", {7'd0, got}, 8'd1);
        idle(WIN + 2);
        unlock(1'b1);
        idle(WIN);
        wr(ma(3'd5, 10'h2), 8'h22, got); chk("R4 gap after unlock too long", {7'd0, got}, 8'd0);
        cmd(1'b0, 12'h555, 8'hAA); cmd(1'b0, 12'hAAA, 8'h55);
        idle(WIN);
        wr(ca(1'b0, 12'h555), 8'hA0, got); chk("R4 mid-sequence gap", {7'd0, got}, 8'd0);
        wr(ma(3'd0, 10'h3), 8'h23, got); chk("R4 no unlock after aborted seq", {7'd0, got}, 8'd0);
        idle(WIN + 2);

        // R8: wrong data mid-sequence
        cmd(1'b0, 12'h555, 8'hAA); cmd(1'b0, 12'hAAA, 8'h55);
        wr(ca(1'b0, 12'h555), 8'hA1, got); chk("R8 wrong byte refused", {7'd0, got}, 8'd0);
        wr(ma(3'd1, 10'h4), 8'h24, got); chk("R8 wrong byte aborts", {7'd0, got}, 8'd0);

        // R9: region and plane mismatches
        wr({3'b001, 1'b0, 12'h555}, 8'hAA, got); chk("R9 bad region byte", {7'd0, got}, 8'd0);
        cmd(1'b0, 12'hAAA, 8'h55);
        wr(ca(1'b0, 12'h555), 8'hA0, got); chk("R9 region abort step", {7'd0, got}, 8'd0);
        wr(ma(3'd1, 10'h5), 8'h25, got); chk("R9 region mismatch no unlock", {7'd0, got}, 8'd0);
        cmd(1'b0, 12'h555, 8'hAA); cmd(1'b1, 12'hAAA, 8'h55); cmd(1'b0, 12'h555, 8'hA0);
        wr(ma(3'd1, 10'h6), 8'h26, got); chk("R9 plane mismatch no unlock", {7'd0, got}, 8'd0);

        // R6: load lock map
        setlock(1'b0, 8'h05);
        #1;
        chk("R6 lock map loaded", lock_map, 8'h05);
        chk("R6 protection on after load", {7'd0, prot_on}, 8'd1);

        // R5: deactivate
        deact(1'b1);
        #1;
        chk("R5 protection off", {7'd0, prot_on}, 8'd0);
        chk("R7 lock kept by deactivate", lock_map, 8'h05);

        // R7 with protection off
        wr(ma(3'd0, 10'h7), 8'h31, got); chk("R7 block0 locked", {7'd0, got}, 8'd0);
        wr(ma(3'd1, 10'h7), 8'h32, got); chk("R5 block1 open", {7'd0, got}, 8'd1);
        wr(ma(3'd2, 10'h7), 8'h33, got); chk("R7 block2 locked", {7'd0, got}, 8'd0);
        wr(ma(3'd7, 10'h7), 8'h34, got); chk("R5 block7 open", {7'd0, got}, 8'd1);

        // R6 re-protect and R7 under unlock
        setlock(1'b1, 8'h80);
        #1;
        chk("R6 reprotect", {7'd0, prot_on}, 8'd1);
        unlock(1'b1);
        wr(ma(3'd7, 10'h8), 8'h35, got); chk("R7 locked under unlock", {7'd0, got}, 8'd0);
        wr(ma(3'd6, 10'h8), 8'h36, got); chk("R3 open block under unlock", {7'd0, got}, 8'd1);
        idle(WIN + 2);

        // R8 with protection off: AA@555 is consumed
        deact(1'b0);
        wr(ca(1'b0, 12'h555), 8'hAA, got); chk("R8 AA@555 consumed when off", {7'd0, got}, 8'd0);
        wr(ma(3'd3, 10'h9), 8'h37, got); chk("R8 wrong step after AA", {7'd0, got}, 8'd0);
        wr(ma(3'd3, 10'h9), 8'h38, got); chk("R5 idle write allowed", {7'd0, got}, 8'd1);

        // Random: protected, no sequence
        rl = 8'($urandom);
        setlock(1'b0, rl);
        #1;
        chk("R6 random lock value", lock_map, rl);
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            d = 8'($urandom);
            if (d == 8'hAA) d = 8'hAB;
            wr(a, d, got);
            chk("R2 random protected write", {7'd0, got}, 8'd0);
        end

        // Random: protection off, lock veto only
        deact(1'b1);
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            d = 8'($urandom);
            if (d == 8'hAA) d = 8'h01;
            wr(a, d, got);
            chk("R7 random unprotected write", {7'd0, got}, {7'd0, exp_open(rl, a)});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule